// File: doc/BRIEF.md
# DSP-to-DAC Source Router and Summer

This block connects four DSP channel sample streams to two DAC output lanes. Each channel has a 3-bit operating mode, and each DAC lane has a 4-bit source field. These fields are held in configuration registers. The registers take new values only while the system-enable input is low.

When every channel mode is zero (disabled), the block switches to bypass by itself. In bypass, each lane's source field is read as the index of a raw input stream, and that stream is forwarded to the DAC unchanged. When any channel is active, the same field is read as a mask. Each set bit adds the matching DSP channel's output into the lane sum. The sum is formed at a wider internal width and then saturated to 16-bit signed.

A legality checker watches the latched configuration and raises an error flag when the configuration is not allowed. This covers reserved mode codes, and the DUC mode on the upper channels while the 4x or 6x interpolation code is selected. Output samples are registered, and a valid flag travels with them.

Top module: `dsp_dac_router`

## Requirements
- R1: After reset, all channel modes are 0, the source field of lane A is 1 and that of lane B is 2, the interpolation code is 0, `out_valid` is low, `bypass` is high and `cfg_err` is low.
- R2: `bypass` is high exactly when all four latched channel modes are 0 (disabled). Mode codes are: 1 DUC, 2 register-driven DDS, 3 vector DDS, 4 streamed DDS, and 5 to 7 reserved.
- R3: In bypass, a lane whose source value is k outputs raw stream k (k from 0 to 3). A source value of 4 or above outputs zero.
- R4: Outside bypass, bit n of a lane's source field adds DSP channel n to that lane's sum. A mask of zero outputs zero.
- R5: The lane sum saturates to the range -32768 to 32767.
- R6: `cfg_err` is high while any latched channel mode is 5, 6 or 7.
- R7: `cfg_err` is high while the interpolation code is 3 (4x) or 4 (6x) and channel 2 or channel 3 is in mode 1. Channels 0 and 1 in mode 1 do not raise it.
- R8: A configuration write with `sys_en` high is ignored. Writes with `sys_en` low are latched on the clock edge, and the flags follow in the next cycle.
- R9: Outputs appear one clock after the inputs are presented, and `out_valid` is `in_valid` delayed by one clock.
- R10: Field layout: the mode of channel n is `cfg_mode[3n+2:3n]`, and the source of lane d is `cfg_src[4d+3:4d]`, where lane 0 is A. Sample n of a packed bus is bits `[16n+15:16n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_en | input | 1 | System enable; configuration is frozen while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 12 | Four 3-bit channel modes |
| cfg_src | input | 8 | Two 4-bit lane source fields |
| cfg_interp | input | 4 | Interpolation code |
| in_valid | input | 1 | Input samples valid |
| raw_in | input | 64 | Four raw bypass streams |
| dsp_in | input | 64 | Four DSP channel outputs |
| dac_out | output | 32 | Two lane samples |
| out_valid | output | 1 | Output samples valid |
| bypass | output | 1 | Bypass operation active |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
A configuration write is latched on the first edge after it is presented. `bypass` and `cfg_err` are therefore read at the falling edge that follows that edge. Sample inputs are driven on a falling edge, and `dac_out` and `out_valid` are read on the next falling edge, one register later. Every check samples halfway between rising edges, so each result is read in the exact cycle it becomes due. The sweeps cover every source value in bypass, every mask with both ordinary and extreme samples, and every reserved code on every channel.

// File: rtl/dsprt_pkg.sv
package dsprt_pkg;
    parameter int NUM_CH     = 4;
    parameter int NUM_LANE   = 2;
    parameter int NUM_STREAM = 4;
    parameter int SAMP_W     = 16;
    parameter int MODE_W     = 3;
    parameter int SRC_W      = 4;
    parameter int INTERP_W   = 4;
    parameter int DUC_LOW_CH = 2;

    localparam int SUM_W = SAMP_W + $clog2(NUM_CH) + 1;

    typedef enum logic [MODE_W-1:0] {
        CM_OFF    = 3'd0,
        CM_DUC    = 3'd1,
        CM_DDSREG = 3'd2,
        CM_DDSVEC = 3'd3,
        CM_DDSSTR = 3'd4
    } chan_mode_e;

    localparam logic [INTERP_W-1:0] INTERP_4X = 4'd3;
    localparam logic [INTERP_W-1:0] INTERP_6X = 4'd4;

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [SAMP_W-1:0] samp_t;

    typedef struct packed {
        logic [NUM_CH-1:0][MODE_W-1:0] mode;
        logic [NUM_LANE-1:0][SRC_W-1:0] src;
        logic [INTERP_W-1:0]            interp;
    } cfg_t;

    function automatic samp_t sat_samp(input logic signed [SUM_W-1:0] v);
        logic signed [SUM_W-1:0] hi;
        logic signed [SUM_W-1:0] lo;
        hi = SUM_W'((1 << (SAMP_W-1)) - 1);
        lo = -SUM_W'(1 << (SAMP_W-1));
        if (v > hi)      return samp_t'(hi);
        else if (v < lo) return samp_t'(lo);
        else             return v[SAMP_W-1:0];
    endfunction
endpackage

// File: rtl/dsprt_cfg_regs.sv
module dsprt_cfg_regs
    import dsprt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sys_en,
    input  logic cfg_we,
    input  cfg_t cfg_new,
    output cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode   <= '0;
            cfg_q.interp <= '0;
            for (int d = 0; d < NUM_LANE; d++)
                cfg_q.src[d] <= SRC_W'(d + 1);
        end else if (cfg_we && !sys_en) begin
            cfg_q <= cfg_new;
        end
    end
endmodule

// File: rtl/dsprt_legality.sv
module dsprt_legality
    import dsprt_pkg::*;
(
    input  cfg_t cfg,
    output logic all_off,
    output logic err
);
    always_comb begin
        all_off = 1'b1;
        err     = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (cfg.mode[c] != CM_OFF) all_off = 1'b0;
            if (cfg.mode[c] > CM_DDSSTR) err = 1'b1;
            if (c >= DUC_LOW_CH && cfg.mode[c] == CM_DUC &&
                (cfg.interp == INTERP_4X || cfg.interp == INTERP_6X))
                err = 1'b1;
        end
    end
endmodule

// File: rtl/dsprt_lane.sv
module dsprt_lane
    import dsprt_pkg::*;
(
    input  src_t                         src,
    input  logic                         bypass,
    input  logic [NUM_STREAM-1:0][SAMP_W-1:0] raw,
    input  logic [NUM_CH-1:0][SAMP_W-1:0]     dsp,
    output samp_t                        y
);
    logic signed [SUM_W-1:0] acc;
    samp_t                   pick;

    always_comb begin
        acc = '0;
        for (int n = 0; n < NUM_CH; n++)
            if (src[n])
                acc = acc + {{(SUM_W-SAMP_W){dsp[n][SAMP_W-1]}}, dsp[n]};
        pick = '0;
        for (int k = 0; k < NUM_STREAM; k++)
            if (src == SRC_W'(k)) pick = raw[k];
        y = bypass ? pick : sat_samp(acc);
    end
endmodule

// File: rtl/dsp_dac_router.sv
module dsp_dac_router
    import dsprt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sys_en,
    input  logic                          cfg_we,
    input  logic [NUM_CH*MODE_W-1:0]      cfg_mode,
    input  logic [NUM_LANE*SRC_W-1:0]     cfg_src,
    input  logic [INTERP_W-1:0]           cfg_interp,
    input  logic                          in_valid,
    input  logic [NUM_STREAM*SAMP_W-1:0]  raw_in,
    input  logic [NUM_CH*SAMP_W-1:0]      dsp_in,
    output logic [NUM_LANE*SAMP_W-1:0]    dac_out,
    output logic                          out_valid,
    output logic                          bypass,
    output logic                          cfg_err
);
    cfg_t cfg_new, cfg_q;
    logic all_off;
    logic [NUM_LANE-1:0][SAMP_W-1:0] lane_y;

    assign cfg_new.mode   = cfg_mode;
    assign cfg_new.src    = cfg_src;
    assign cfg_new.interp = cfg_interp;

    dsprt_cfg_regs u_regs (
        .clk(clk), .rst(rst), .sys_en(sys_en), .cfg_we(cfg_we),
        .cfg_new(cfg_new), .cfg_q(cfg_q)
    );

    dsprt_legality u_legal (
        .cfg(cfg_q), .all_off(all_off), .err(cfg_err)
    );

    assign bypass = all_off;

    for (genvar d = 0; d < NUM_LANE; d++) begin : g_lane
        dsprt_lane u_lane (
            .src(cfg_q.src[d]), .bypass(all_off),
            .raw(raw_in), .dsp(dsp_in), .y(lane_y[d])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_out   <= '0;
            out_valid <= 1'b0;
        end else begin
            dac_out   <= lane_y;
            out_valid <= in_valid;
        end
    end
endmodule

// File: rtl/dsprt_chk.sv
module dsprt_chk
    import dsprt_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     sys_en,
    input logic                     cfg_we,
    input logic [NUM_CH*MODE_W-1:0] cfg_mode,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic                     bypass,
    input logic                     cfg_err
);
    // R9
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    frozen_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        sys_en |=> $stable(bypass));
    // R8
    frozen_err_chk: assert property (@(posedge clk) disable iff (rst)
        sys_en |=> $stable(cfg_err));
    // R6
    reserved_code_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !sys_en && cfg_mode[MODE_W-1:0] > 3'd4) |=> cfg_err);
    // R2
    active_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !sys_en && cfg_mode != '0) |=> !bypass);
endmodule

bind dsp_dac_router dsprt_chk u_chk (
    .clk(clk), .rst(rst), .sys_en(sys_en), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .in_valid(in_valid), .out_valid(out_valid),
    .bypass(bypass), .cfg_err(cfg_err)
);

// File: tb/sim_dsp_dac_router.sv
module sim_dsp_dac_router;
    import dsprt_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1, sys_en = 0, cfg_we = 0, in_valid = 0;
    logic [11:0] cfg_mode = '0;
    logic [7:0]  cfg_src = '0;
    logic [3:0]  cfg_interp = '0;
    logic [63:0] raw_in = '0, dsp_in = '0;
    logic [31:0] dac_out;
    logic out_valid, bypass, cfg_err;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsp_dac_router u0 (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [11:0] m, input logic [7:0] s,
                             input logic [3:0] ip, input logic en);
        @(negedge clk);
        cfg_mode = m; cfg_src = s; cfg_interp = ip; sys_en = en; cfg_we = 1;
        @(negedge clk);
        cfg_we = 0; sys_en = 1;
    endtask

    task automatic drive(input logic [63:0] r, input logic [63:0] d, input logic v);
        raw_in = r; dsp_in = d; in_valid = v;
        @(negedge clk);
    endtask

    function automatic int sx(input logic [15:0] v);
        return int'(signed'(v));
    endfunction

    function automatic logic [15:0] exp_sum(input logic [3:0] m, input logic [63:0] d);
        int s = 0;
        for (int n = 0; n < 4; n++) if (m[n]) s += sx(d[16*n +: 16]);
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return 16'(s);
    endfunction

    initial begin
        #(CLK_PERIOD*150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] rv, dv;
        rv = 64'h4444_3333_2222_1111;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 bypass", bypass, 1);
        chk("R1 cfg_err", cfg_err, 0);
        drive(rv, 64'h0, 1);
        chk("R1 lane A default src", dac_out[15:0], 16'h2222);
        chk("R1 lane B default src", dac_out[31:16], 16'h3333);
        chk("R9 out_valid follows", out_valid, 1);
        drive(rv, 64'h0, 0);
        chk("R9 out_valid drops", out_valid, 0);

        // R3 bypass sweep: every source value on both lanes
        for (int a = 0; a < 16; a++) begin
            write_cfg(12'h0, {4'(15 - a), 4'(a)}, 4'd0, 0);
            chk("R2 bypass flag", bypass, 1);
            drive(rv, 64'hFFFF_FFFF_FFFF_FFFF, 1);
            chk("R3 lane A stream", dac_out[15:0], a < 4 ? rv[16*a +: 16] : 0);
            chk("R3 lane B stream", dac_out[31:16], (15 - a) < 4 ? rv[16*(15 - a) +: 16] : 0);
        end

        // R4/R5 DSP summing, every mask, several sample patterns (R10 layout)
        for (int p = 0; p < 4; p++) begin
            case (p)
                0: dv = 64'h0004_0003_0002_0001;
                1: dv = 64'h7FFF_7FFF_7FFF_7FFF;
                2: dv = 64'h8000_8000_8000_8000;
                default: dv = 64'hC000_1234_FFFF_4000;
            endcase
            for (int m = 0; m < 16; m++) begin
                write_cfg(12'h249, {4'(~m), 4'(m)}, 4'd5, 0);
                chk("R2 bypass off", bypass, 0);
                drive(rv, dv, 1);
                chk("R4 R5 lane A sum", dac_out[15:0], exp_sum(4'(m), dv));
                chk("R4 R5 lane B sum", dac_out[31:16], exp_sum(4'(~m), dv));
            end
        end

        // R6 reserved codes on every channel
        for (int c = 0; c < 4; c++)
            for (int code = 5; code < 8; code++) begin
                write_cfg(12'(code) << (3*c), 8'h21, 4'd5, 0);
                chk("R6 reserved flagged", cfg_err, 1);
            end
        for (int code = 1; code < 5; code++) begin
            write_cfg({4{3'(code)}}, 8'h21, 4'd5, 0);
            chk("R6 legal code no err", cfg_err, 0);
        end

        // R7 DUC limits under 4x/6x
        for (int ip = 3; ip < 6; ip++)
            for (int c = 0; c < 4; c++) begin
                write_cfg(12'(1) << (3*c), 8'h21, 4'(ip), 0);
                chk("R7 DUC channel limit", cfg_err, (ip < 5 && c >= 2) ? 1 : 0);
            end

        // R8 writes while enabled are ignored
        write_cfg(12'h0, 8'h10, 4'd0, 0);
        write_cfg(12'h7, 8'h23, 4'd0, 1);
        chk("R8 bypass kept", bypass, 1);
        chk("R8 err kept", cfg_err, 0);
        drive(rv, 64'h0, 1);
        chk("R8 lane A src kept", dac_out[15:0], 16'h1111);
        chk("R8 lane B src kept", dac_out[31:16], 16'h2222);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule